// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flags

This block holds a small set of event flags for a peripheral. Hardware sets each flag with a one-cycle pulse, and the flag stays set until software clears it. Software clears a flag in two steps. It first reads the status register while the flag is 1, which arms that flag. It then reads or writes the data register that belongs to the flag, which clears it. Each flag has its own data register.

While a debugger holds the program halted, the `brk_active` input is high. A clear-enable control bit then decides what software may do. With the bit at 0, the debugger can read and write every register without destroying flag information, and a clear sequence begun before the halt stays pending so it can finish afterwards. With the bit at 1, clearing works during the halt exactly as it does outside it.

Top module: `brk_status_flags`

## Requirements
- R1: After reset all flags are 0, no flag is armed, the clear-enable bit is 0 and `flag_any` is 0.
- R2: A 1 on `set_evt[i]` in a cycle makes flag i read as 1 from the next cycle on, and flag i stays 1 until a clear.
- R3: Outside protection, reading the status register (address 0, flag i at data bit i) and then accessing data register i (address 2+i) clears flag i at the end of that access.
- R4: An access to data register i clears nothing unless a status read armed flag i earlier.
- R5: A status read arms only the flags that are 1 at that moment. A flag set after the read is not cleared by the next data access.
- R6: Protection is in force when `brk_active` is 1 and the clear-enable bit is 0. Under protection, status reads and data accesses change neither the flags nor their armed state.
- R7: A flag armed before protection begins stays armed through it. The first data access after protection ends then clears the flag.
- R8: When the clear-enable bit is 1, the two-step clear works while `brk_active` is 1, and the cleared flag stays 0 after `brk_active` falls.
- R9: When a set pulse and a completing data access hit the same flag in the same cycle, the flag ends up 1.
- R10: The control register at address 1 holds the clear-enable bit in data bit 0. That bit is written from `reg_wdata[0]` and reads back with all other bits 0.
- R11: The data registers can be written and read at any time, including under protection, and they keep their values.
- R12: `flag_any` is 1 exactly when at least one flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_active | input | 1 | High while the debugger has halted the program |
| set_evt | input | NUM_FLAGS | One-cycle hardware set pulses, one per flag |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational in the read cycle, 0 when not reading |
| flag_any | output | 1 | OR of all flags |

## Verification
Read data is combinational, so the bench checks `reg_rdata` during the same cycle as the read strobe. It samples 3 ns after the falling edge at which the driver applied the strobe. A set pulse, an arming read or a clearing access takes effect at the next rising edge, so its result first shows up in the register read in the following cycle. The driver pushes each expected read value, together with the expected `flag_any`, into a queue at the moment it issues the read. The monitor pops that entry in the same cycle, so every comparison belongs to the cycle its stimulus implies.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    // Register address layout: status, control, then one data register per flag
    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned CTRL_OFS   = 1;
    localparam int unsigned DATA_OFS   = 2;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_STATUS,
        RK_CTRL,
        RK_DATA
    } reg_kind_e;

    // Decoded bus operation carried between decode and datapath
    typedef struct packed {
        logic      stat_arm;   // status read that may arm flags
        logic      ctrl_wr;    // write of the control register
        reg_kind_e kind;       // which register is addressed
    } bus_op_t;

    function automatic reg_kind_e classify(input int unsigned a, input int unsigned n);
        if (a == STATUS_OFS)                   return RK_STATUS;
        if (a == CTRL_OFS)                     return RK_CTRL;
        if (a >= DATA_OFS && a < DATA_OFS + n) return RK_DATA;
        return RK_NONE;
    endfunction

endpackage

// File: rtl/bsf_decode.sv
module bsf_decode
    import bsf_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned ADDR_W    = 3,
    localparam int unsigned IDX_W    = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 protect,
    output bus_op_t              op,
    output logic [NUM_FLAGS-1:0] clr_req,
    output logic [NUM_FLAGS-1:0] data_wr,
    output logic [IDX_W-1:0]     data_idx
);

    reg_kind_e kind;

    always_comb begin
        kind        = classify(32'(addr), NUM_FLAGS);
        op.kind     = kind;
        // A status read under protection must not arm anything (R6)
        op.stat_arm = rd && (kind == RK_STATUS) && !protect;
        op.ctrl_wr  = wr && (kind == RK_CTRL);
        data_idx    = IDX_W'(32'(addr) - DATA_OFS);
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
        logic hit;
        assign hit        = (kind == RK_DATA) && (32'(addr) == 32'(DATA_OFS + i));
        // Second clear step: any access, blocked under protection (R6)
        assign clr_req[i] = hit && (rd || wr) && !protect;
        // Data register writes are always allowed (R11)
        assign data_wr[i] = hit && wr;
    end

endmodule

// File: rtl/bsf_flag_slice.sv
module bsf_flag_slice (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic arm_req,
    input  logic clr_req,
    output logic flag_q,
    output logic armed_q
);

    logic finish;
    logic flag_d;
    logic armed_d;

    always_comb begin
        finish = clr_req && armed_q;
        // A set pulse in the same cycle as a completing clear wins (R9)
        flag_d = set_pulse || (flag_q && !finish);
        if (finish)
            armed_d = 1'b0;              // sequence consumed (R3)
        else if (arm_req && flag_q)
            armed_d = 1'b1;              // only a set flag arms (R5)
        else
            armed_d = armed_q;           // kept through protection (R7)
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

endmodule

// File: rtl/bsf_data_bank.sv
module bsf_data_bank #(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_FLAGS-1:0]              wr_en,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_FLAGS-1:0][DATA_W-1:0]  data_q
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                data_q[i] <= '0;
            else if (wr_en[i])
                data_q[i] <= wdata;
        end
    end

endmodule

// File: rtl/brk_status_flags.sv
module brk_status_flags
    import bsf_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 brk_active,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 flag_any
);

    localparam int unsigned IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

    bus_op_t                            op;
    logic                               protect;
    logic                               clr_en_q;
    logic                               ctrl_wr;
    logic [NUM_FLAGS-1:0]               clr_req;
    logic [NUM_FLAGS-1:0]               data_wr;
    logic [IDX_W-1:0]                   data_idx;
    logic [NUM_FLAGS-1:0]               flags_q;
    logic [NUM_FLAGS-1:0]               armed_q;
    logic [NUM_FLAGS-1:0][DATA_W-1:0]   data_q;

    // Protection: halted and clearing not enabled (R6)
    assign protect = brk_active && !clr_en_q;
    assign ctrl_wr = op.ctrl_wr;

    bsf_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .protect  (protect),
        .op       (op),
        .clr_req  (clr_req),
        .data_wr  (data_wr),
        .data_idx (data_idx)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        bsf_flag_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .set_pulse (set_evt[i]),
            .arm_req   (op.stat_arm),
            .clr_req   (clr_req[i]),
            .flag_q    (flags_q[i]),
            .armed_q   (armed_q[i])
        );
    end

    bsf_data_bank #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (data_wr),
        .wdata  (reg_wdata),
        .data_q (data_q)
    );

    // Clear-enable bit, protected by default after reset (R1, R10)
    always_ff @(posedge clk) begin
        if (rst)
            clr_en_q <= 1'b0;
        else if (ctrl_wr)
            clr_en_q <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (op.kind)
                RK_STATUS: reg_rdata = DATA_W'(flags_q);
                RK_CTRL:   reg_rdata = DATA_W'(clr_en_q);
                RK_DATA:   reg_rdata = data_q[data_idx];
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign flag_any = |flags_q;   // R12

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
    parameter int unsigned NUM_FLAGS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_FLAGS-1:0] set_evt,
    input logic                 protect,
    input logic                 ctrl_wr,
    input logic                 wdata_b0,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] armed,
    input logic                 clr_en
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags == '0 && armed == '0 && !clr_en)); // R1

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R2

    AST_ONLY_ARMED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flags & $past(flags) & ~$past(armed)) == '0)); // R4

    AST_ARM_SUBSET: assert property (@(posedge clk) disable iff (rst)
        ((armed & ~flags) == '0)); // R5

    AST_PROTECT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        protect |=> (armed == $past(armed)
                     && (flags & ~$past(set_evt)) == ($past(flags) & ~$past(set_evt)))); // R6

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (clr_en == $past(wdata_b0))); // R10

endmodule

bind brk_status_flags bsf_checker #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (set_evt),
    .protect  (protect),
    .ctrl_wr  (ctrl_wr),
    .wdata_b0 (reg_wdata[0]),
    .flags    (flags_q),
    .armed    (armed_q),
    .clr_en   (clr_en_q)
);

// File: tb/tb_brk_status_flags.sv
module tb_brk_status_flags;

    localparam int NF = 4;
    localparam int DW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          brk_active = 1'b0;
    logic [NF-1:0] set_evt = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          flag_any;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic brk_v = 1'b0;

    typedef struct {
        logic [DW-1:0] dat;
        logic          any;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    brk_status_flags #(.NUM_FLAGS(NF), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk        (clk),
        .rst        (rst),
        .brk_active (brk_active),
        .set_evt    (set_evt),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .flag_any   (flag_any)
    );

    // Driver: one bus cycle per call, applied at the falling edge
    task automatic bus(input logic rd, input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [NF-1:0] s,
                       input logic [DW-1:0] ed, input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        brk_active = brk_v;
        reg_rd     = rd;
        reg_wr     = wr;
        reg_addr   = a;
        reg_wdata  = wd;
        set_evt    = s;
        if (rd) begin
            e.dat = ed; e.any = ea; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] ed, input logic ea, input string tag);
        bus(1'b1, 1'b0, a, '0, '0, ed, ea, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus(1'b0, 1'b1, a, d, '0, '0, 1'b0, "");
    endtask

    task automatic pulse(input logic [NF-1:0] m);
        bus(1'b0, 1'b0, '0, '0, m, '0, 1'b0, "");
    endtask

    // Monitor: compares in the cycle of the read strobe
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && reg_rd) begin
                exp_t e;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected read: actual=%h expected=none", reg_rdata);
                end else begin
                    e = exp_q.pop_front();
                    if (reg_rdata !== e.dat || flag_any !== e.any) begin
                        bad++;
                        $display("FAIL %s: actual data=%h any=%b expected data=%h any=%b",
                                 e.tag, reg_rdata, flag_any, e.dat, e.any);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 8'h00, 1'b0, "R1 status");
        rd(1, 8'h00, 1'b0, "R1 ctrl");

        // R2 set, R3 normal clear
        pulse(4'b0001);
        rd(0, 8'h01, 1'b1, "R2 set");
        rd(2, 8'h00, 1'b1, "R11 data0 reset");
        rd(0, 8'h00, 1'b0, "R3 cleared");

        // R4: access without arming clears nothing
        pulse(4'b0010);
        wr(3, 8'h5A);
        rd(0, 8'h02, 1'b1, "R4 no arm");
        rd(3, 8'h5A, 1'b1, "R11 data1");
        rd(0, 8'h00, 1'b0, "R3 cleared by read");

        // R5: late-set flag not armed
        pulse(4'b0001);
        rd(0, 8'h01, 1'b1, "R5 arm0");
        pulse(4'b0010);
        rd(3, 8'h5A, 1'b1, "R5 access1");
        rd(0, 8'h03, 1'b1, "R5 late flag kept");
        rd(2, 8'h00, 1'b1, "R3 access0");
        rd(3, 8'h5A, 1'b1, "R3 access1");
        rd(0, 8'h00, 1'b0, "R3 both cleared");

        // R6: protected break
        pulse(4'b0100);
        brk_v = 1'b1;
        rd(0, 8'h04, 1'b1, "R6 read in break");
        rd(4, 8'h00, 1'b1, "R11 data2");
        wr(4, 8'h33);
        rd(0, 8'h04, 1'b1, "R6 kept");
        rd(4, 8'h33, 1'b1, "R11 write in break");
        brk_v = 1'b0;
        rd(4, 8'h33, 1'b1, "R6 not armed in break");
        rd(0, 8'h04, 1'b1, "R6 still set");

        // R7: armed before break finishes after
        brk_v = 1'b1;
        rd(4, 8'h33, 1'b1, "R7 access in break");
        wr(4, 8'h44);
        rd(0, 8'h04, 1'b1, "R7 held in break");
        brk_v = 1'b0;
        rd(4, 8'h44, 1'b1, "R7 second step");
        rd(0, 8'h00, 1'b0, "R7 cleared after break");

        // R10 control, R8 clear enabled during break
        wr(1, 8'hFF);
        rd(1, 8'h01, 1'b0, "R10 ctrl set");
        pulse(4'b1000);
        brk_v = 1'b1;
        rd(0, 8'h08, 1'b1, "R8 arm in break");
        rd(5, 8'h00, 1'b1, "R8 access3");
        rd(0, 8'h00, 1'b0, "R8 cleared in break");
        brk_v = 1'b0;
        rd(0, 8'h00, 1'b0, "R8 stays cleared");
        wr(1, 8'h00);
        rd(1, 8'h00, 1'b0, "R10 ctrl clear");

        // R9: set wins over clear
        pulse(4'b0001);
        rd(0, 8'h01, 1'b1, "R9 arm");
        bus(1'b1, 1'b0, 3'd2, '0, 4'b0001, 8'h00, 1'b1, "R9 access");
        rd(0, 8'h01, 1'b1, "R9 set wins");
        rd(2, 8'h00, 1'b1, "R3 access0 again");
        rd(0, 8'h00, 1'b0, "R3 clear after R9");

        // R12: OR of several flags
        pulse(4'b1010);
        rd(0, 8'h0A, 1'b1, "R12 any");

        bus(1'b0, 1'b0, '0, '0, '0, '0, 1'b0, "");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL queue: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule